// File: doc/BRIEF.md
# Genlock Reference Input Conditioner

This block prepares the external reference signals that a subcarrier lock loop follows. A square-wave reference arrives either at the subcarrier frequency or at four times that frequency. It is brought into the 27 MHz pixel clock domain through a synchronizer, and its rising edges become single-cycle reference-phase events for a downstream phase detector. In the four-times mode a divide-by-four counter keeps only every fourth rising edge. A separate sync input forces that counter back to its zero state, so the phase of the divided reference is set from outside the block.

The block also produces the V-axis inversion control used for PAL chroma. When genlock is on and the format is PAL, the line-identification input is sampled once per line at a fixed pixel-sample count, and the sampled value becomes the inversion control at the start of the next line. A high line-identification level means a burst phase of −135° and gives inversion 1. A low level means +135° and gives inversion 0. With genlock off and PAL selected, the inversion control toggles at every line start. With a non-PAL format it stays at 0.

The nominal subcarrier frequency must be set up before genlock is enabled. The lock loop pulls in over about ±2 kHz. The phase detector and the loop filter lie outside this block.

Top module: `gref_cond`

## Requirements
- R1: After a synchronous active-low reset, `ref_evt`, `div_phase` and `vinv` are all 0.
- R2: With genlock on and `quad_ref`=0, each rising edge of `ref_in` produces exactly one `ref_evt` pulse. The pulse is high for the one cycle that follows the third rising clock edge after the new level is first sampled.
- R3: With genlock on and `quad_ref`=1, `div_phase` advances by one (mod 4) on each synchronized rising edge of `ref_in`. `ref_evt` pulses only for a rising edge that arrives while `div_phase` is 0, which gives one event per four reference edges.
- R4: With genlock on and `quad_ref`=1, a synchronized rising edge of `sync_in` sets `div_phase` to 0. If a reference rising edge arrives in the same cycle, the sync wins: no event is produced and the count does not advance.
- R5: With `genlock_en`=0, the cycle after holds `ref_evt`=0 and `div_phase`=0.
- R6: With `genlock_en`=1 and `pal_mode`=1, `pal_id_in` is sampled when `sample_cnt`=1444. At the next `sample_cnt`=0, `vinv` takes the sampled value (1 = −135° burst, 0 = +135°).
- R7: `pal_id_in` values at any sample count other than 1444 have no effect on `vinv`, and `vinv` changes only on the edge where `sample_cnt`=0.
- R8: With `genlock_en`=0 and `pal_mode`=1, `vinv` inverts at every `sample_cnt`=0.
- R9: With `pal_mode`=0, `vinv` becomes 0 at the next `sample_cnt`=0.
- R10: `ref_evt` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | External subcarrier reference square wave (asynchronous) |
| sync_in | input | 1 | Divider phase-reset input for the four-times mode (asynchronous) |
| pal_id_in | input | 1 | PAL line identification, synchronous to `clk` |
| genlock_en | input | 1 | Genlock enable |
| quad_ref | input | 1 | 1: reference is at 4×fsc, 0: reference is at fsc |
| pal_mode | input | 1 | 1: PAL output format |
| sample_cnt | input | 11 | Pixel-sample position within the line |
| ref_evt | output | 1 | Single-cycle reference-phase event for the phase detector |
| div_phase | output | 2 | Current state of the divide-by-four counter |
| vinv | output | 1 | V-axis inversion control for the current line |

## Verification
A change on `ref_in` or `sync_in` passes two synchronizer flops and one edge-detect flop. The resulting `ref_evt` pulse and the `div_phase` update therefore appear after the third rising clock edge after the new level is first sampled. `vinv` is registered from the inputs present on the edge where `sample_cnt` is 0, and the capture happens on the edge where `sample_cnt` is 1444. The bench model is updated at each rising edge from the inputs presented there, using queues of past reference and sync levels to account for the three-edge delay. The bench drives inputs and compares outputs on the falling edge, so every comparison sees results that have already settled.

// File: rtl/gref_pkg.sv
// Shared constants and types for the genlock reference conditioner.
package gref_pkg;

    // Default pixel-sample counter width (covers a 1728-sample line).
    localparam int unsigned SAMPLE_W_DEF   = 11;
    // Default sample at which the line-identification input is captured.
    localparam int unsigned CAPTURE_AT_DEF = 1444;
    // Default sample count that marks the start of a line.
    localparam int unsigned LINE_START_DEF = 0;

    // Where the V-axis inversion value for the next line comes from.
    typedef enum logic [1:0] {
        VS_OFF     = 2'd0,   // non-PAL format: no inversion
        VS_TOGGLE  = 2'd1,   // PAL without genlock: internal alternation
        VS_CAPTURE = 2'd2    // PAL with genlock: captured line-id
    } vinv_src_e;

endpackage

// File: rtl/gref_sync.sv
// Multi-stage synchronizer for asynchronous single-bit inputs.
// Assumes: STAGES >= 2; each bit is treated on its own (no bus coherence).
module gref_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], d};
        end
    end

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/gref_div.sv
// Reference edge detection and the reference divider with external phase reset.
// Assumes: ref_s and sync_s are already synchronized to clk.
// In divide mode, the sync rising edge takes priority over a reference edge
// that arrives in the same cycle.
module gref_div #(
    parameter int unsigned DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_s,
    input  logic             sync_s,
    input  logic             en,
    input  logic             quad,
    output logic             evt,
    output logic [DIV_W-1:0] phase
);

    logic             ref_p;
    logic             sync_p;
    logic             ref_rise;
    logic             sync_rise;
    logic             fire;
    logic [DIV_W-1:0] cnt;

    // Hold the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_p  <= 1'b0;
            sync_p <= 1'b0;
        end else begin
            ref_p  <= ref_s;
            sync_p <= sync_s;
        end
    end

    // Decode rising edges and decide whether this edge is a phase event.
    always_comb begin
        ref_rise  = ref_s & ~ref_p;
        sync_rise = sync_s & ~sync_p;
        if (!en) begin
            fire = 1'b0;
        end else if (!quad) begin
            fire = ref_rise;
        end else begin
            fire = ref_rise & (cnt == '0) & ~sync_rise;
        end
    end

    // Divider count: cleared when idle or on sync, else advances per edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en || !quad) begin
            cnt <= '0;
        end else if (sync_rise) begin
            cnt <= '0;
        end else if (ref_rise) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Register the event pulse for the phase detector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt <= 1'b0;
        end else begin
            evt <= fire;
        end
    end

    assign phase = cnt;

endmodule

// File: rtl/gref_lineid.sv
// PAL line-identification capture and the V-axis inversion register.
// Assumes: pal_id and sample_cnt are synchronous to clk; CAPTURE_AT and
// LINE_START are distinct values within the sample counter range.
module gref_lineid
    import gref_pkg::*;
#(
    parameter int unsigned SAMPLE_W   = SAMPLE_W_DEF,
    parameter int unsigned CAPTURE_AT = CAPTURE_AT_DEF,
    parameter int unsigned LINE_START = LINE_START_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic                pal,
    input  logic                pal_id,
    input  logic [SAMPLE_W-1:0] sample_cnt,
    output logic                vinv
);

    localparam logic [SAMPLE_W-1:0] CAP_CNT   = SAMPLE_W'(CAPTURE_AT);
    localparam logic [SAMPLE_W-1:0] START_CNT = SAMPLE_W'(LINE_START);

    logic      pend;
    logic      at_cap;
    logic      at_start;
    vinv_src_e src;

    // Decode the two sample positions this block acts on.
    always_comb begin
        at_cap   = (sample_cnt == CAP_CNT);
        at_start = (sample_cnt == START_CNT);
    end

    // Select where the next line's inversion value comes from.
    always_comb begin
        if (!pal) begin
            src = VS_OFF;
        end else if (!en) begin
            src = VS_TOGGLE;
        end else begin
            src = VS_CAPTURE;
        end
    end

    // Capture the line-id once per line, only in PAL genlock operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (at_cap && (src == VS_CAPTURE)) begin
            pend <= pal_id;
        end
    end

    // Update the inversion control at line start from the selected source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vinv <= 1'b0;
        end else if (at_start) begin
            case (src)
                VS_TOGGLE:  vinv <= ~vinv;
                VS_CAPTURE: vinv <= pend;
                default:    vinv <= 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/gref_cond.sv
// Genlock reference input conditioner: synchronizes the reference and sync
// inputs, divides a 4x reference with sync-driven phase alignment, and
// derives the per-line PAL V-axis inversion control.
// Assumes: ref_in and sync_in are asynchronous with levels lasting at least
// two clk cycles; pal_id_in and sample_cnt are synchronous to clk.
module gref_cond
    import gref_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DIV_W       = 2,
    parameter int unsigned SAMPLE_W    = SAMPLE_W_DEF,
    parameter int unsigned CAPTURE_AT  = CAPTURE_AT_DEF,
    parameter int unsigned LINE_START  = LINE_START_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_in,
    input  logic                sync_in,
    input  logic                pal_id_in,
    input  logic                genlock_en,
    input  logic                quad_ref,
    input  logic                pal_mode,
    input  logic [SAMPLE_W-1:0] sample_cnt,
    output logic                ref_evt,
    output logic [DIV_W-1:0]    div_phase,
    output logic                vinv
);

    localparam int unsigned N_ASYNC = 2;

    logic [N_ASYNC-1:0] async_raw;
    logic [N_ASYNC-1:0] async_s;

    assign async_raw = {sync_in, ref_in};

    gref_sync #(
        .W      (N_ASYNC),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (async_raw),
        .q     (async_s)
    );

    gref_div #(
        .DIV_W (DIV_W)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_s  (async_s[0]),
        .sync_s (async_s[1]),
        .en     (genlock_en),
        .quad   (quad_ref),
        .evt    (ref_evt),
        .phase  (div_phase)
    );

    gref_lineid #(
        .SAMPLE_W   (SAMPLE_W),
        .CAPTURE_AT (CAPTURE_AT),
        .LINE_START (LINE_START)
    ) u_lineid (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (genlock_en),
        .pal        (pal_mode),
        .pal_id     (pal_id_in),
        .sample_cnt (sample_cnt),
        .vinv       (vinv)
    );

endmodule

// File: rtl/gref_cond_chk.sv
// Property checker for gref_cond, attached through bind.
// Assumes: the same parameter values as the bound instance.
module gref_cond_chk #(
    parameter int unsigned DIV_W      = 2,
    parameter int unsigned SAMPLE_W   = 11,
    parameter int unsigned LINE_START = 0
) (
    input logic                clk,
    input logic                rst_n,
    input logic                genlock_en,
    input logic                pal_mode,
    input logic [SAMPLE_W-1:0] sample_cnt,
    input logic                ref_evt,
    input logic [DIV_W-1:0]    div_phase,
    input logic                vinv
);

    localparam logic [SAMPLE_W-1:0] START_CNT = SAMPLE_W'(LINE_START);

    // R10: an event is a single-cycle pulse.
    p_evt_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_evt |=> !ref_evt);

    // R5: genlock off silences events.
    p_no_evt_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !genlock_en |=> !ref_evt);

    // R5: genlock off parks the divider.
    p_phase_zero_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !genlock_en |=> (div_phase == '0));

    // R7: inversion control moves only at line start.
    p_vinv_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_cnt != START_CNT) |=> $stable(vinv));

    // R8: free alternation when PAL runs without genlock.
    p_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_mode && !genlock_en && sample_cnt == START_CNT) |=> (vinv != $past(vinv)));

    // R9: no inversion outside PAL.
    p_nonpal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pal_mode && sample_cnt == START_CNT) |=> !vinv);

endmodule

bind gref_cond gref_cond_chk #(
    .DIV_W      (DIV_W),
    .SAMPLE_W   (SAMPLE_W),
    .LINE_START (LINE_START)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .genlock_en (genlock_en),
    .pal_mode   (pal_mode),
    .sample_cnt (sample_cnt),
    .ref_evt    (ref_evt),
    .div_phase  (div_phase),
    .vinv       (vinv)
);

// File: tb/gref_cond_tb.sv
// Bench for gref_cond: behavioural reference model updated on every rising
// edge, compared against the outputs on every falling edge.
module gref_cond_tb_top;

    localparam int LINE_LEN = 1728;
    localparam int CAP      = 1444;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_in = 1'b0;
    logic        sync_in = 1'b0;
    logic        pal_id_in = 1'b0;
    logic        genlock_en = 1'b0;
    logic        quad_ref = 1'b0;
    logic        pal_mode = 1'b0;
    logic [10:0] sample_cnt = '0;
    logic        ref_evt;
    logic [1:0]  div_phase;
    logic        vinv;

    int errors = 0;
    int checks = 0;

    // stimulus controls
    bit ref_run = 1'b0;
    int ref_half = 5;
    int ref_ph = 0;
    int line_no = 0;
    bit glitch = 1'b0;
    bit last_want = 1'b0;

    // model state
    bit q_ref[$];
    bit q_sync[$];
    bit m_evt = 1'b0;
    int m_cnt = 0;
    bit m_vinv = 1'b0;
    bit m_pend = 1'b0;
    bit prev_evt = 1'b0;
    int pairs = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    gref_cond dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_in     (ref_in),
        .sync_in    (sync_in),
        .pal_id_in  (pal_id_in),
        .genlock_en (genlock_en),
        .quad_ref   (quad_ref),
        .pal_mode   (pal_mode),
        .sample_cnt (sample_cnt),
        .ref_evt    (ref_evt),
        .div_phase  (div_phase),
        .vinv       (vinv)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
        end
    endtask

    // Drive the free-running sample counter, reference and line-id.
    always @(negedge clk) begin
        bit want;
        if (!rst_n) begin
            sample_cnt = '0;
            line_no = 0;
        end else begin
            if (sample_cnt == 11'(LINE_LEN - 1)) begin
                sample_cnt = '0;
                line_no++;
            end else begin
                sample_cnt = sample_cnt + 1'b1;
            end
        end
        if (ref_run) begin
            ref_ph++;
            ref_in = ((ref_ph % (2 * ref_half)) < ref_half);
        end
        want = (line_no % 4 == 1) || (line_no % 4 == 2);
        if (sample_cnt == 11'(CAP)) begin
            pal_id_in = want;
            last_want = want;
        end else begin
            pal_id_in = glitch ? ~want : want;
        end
    end

    // Reference model, evaluated with the inputs present at each rising edge.
    always @(posedge clk) begin
        bit r_now, r_old, s_now, s_old, rise, srise;
        if (!rst_n) begin
            q_ref = '{1'b0, 1'b0, 1'b0};
            q_sync = '{1'b0, 1'b0, 1'b0};
            m_evt = 1'b0; m_cnt = 0; m_vinv = 1'b0; m_pend = 1'b0;
        end else begin
            q_ref.push_back(ref_in);
            q_sync.push_back(sync_in);
            if (q_ref.size() > 8) void'(q_ref.pop_front());
            if (q_sync.size() > 8) void'(q_sync.pop_front());
            r_now = q_ref[q_ref.size() - 3];
            r_old = q_ref[q_ref.size() - 4];
            s_now = q_sync[q_sync.size() - 3];
            s_old = q_sync[q_sync.size() - 4];
            rise  = r_now && !r_old;
            srise = s_now && !s_old;
            m_evt = genlock_en && rise && (!quad_ref || (m_cnt == 0 && !srise));
            if (!genlock_en || !quad_ref) m_cnt = 0;
            else if (srise) m_cnt = 0;
            else if (rise) m_cnt = (m_cnt + 1) % 4;
            if (genlock_en && pal_mode && sample_cnt == 11'(CAP)) m_pend = pal_id_in;
            if (sample_cnt == 11'd0) begin
                if (!pal_mode) m_vinv = 1'b0;
                else if (!genlock_en) m_vinv = !m_vinv;
                else m_vinv = m_pend;
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        string te, tv;
        if (rst_n) begin
            te = !genlock_en ? "R5" : (quad_ref ? "R3" : "R2");
            tv = !pal_mode ? "R9" : (genlock_en ? "R6" : "R8");
            check(te, ref_evt, m_evt);
            check(quad_ref ? "R4" : "R5", div_phase, m_cnt);
            check(glitch ? "R7" : tv, vinv, m_vinv);
            if (ref_evt && prev_evt) pairs++;
            prev_evt = ref_evt;
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_line_at(input int pos);
        do @(negedge clk); while (sample_cnt != 11'(pos));
    endtask

    initial begin
        wait_cyc(5);
        // R1: reset state
        check("R1", ref_evt, 0);
        check("R1", div_phase, 0);
        check("R1", vinv, 0);
        rst_n = 1'b1;

        // R2, R6: fsc reference, PAL genlock capture
        genlock_en = 1'b1; pal_mode = 1'b1; quad_ref = 1'b0;
        ref_half = 5; ref_run = 1'b1;
        wait_cyc(2 * LINE_LEN);
        wait_line_at(100);
        check("R6", vinv, last_want);

        // R7: line-id glitches outside the capture sample
        glitch = 1'b1;
        wait_cyc(LINE_LEN);
        wait_line_at(100);
        check("R7", vinv, last_want);
        glitch = 1'b0;

        // R3: 4x reference
        quad_ref = 1'b1; ref_half = 2;
        wait_cyc(600);

        // R4: sync realigns the divider while the reference is still
        ref_run = 1'b0;
        wait_cyc(6);
        sync_in = 1'b1; wait_cyc(3); sync_in = 1'b0;
        wait_cyc(6);
        check("R4", div_phase, 0);
        ref_run = 1'b1;
        // sync pulses while the reference runs (includes coincident edges)
        for (int k = 0; k < 20; k++) begin
            wait_cyc(37 + k);
            sync_in = 1'b1; wait_cyc(3); sync_in = 1'b0;
        end

        // R5, R8: genlock off with PAL
        genlock_en = 1'b0;
        wait_cyc(2 * LINE_LEN);
        check("R5", div_phase, 0);

        // R9: non-PAL format
        pal_mode = 1'b0;
        wait_cyc(LINE_LEN + 10);
        check("R9", vinv, 0);

        // R10: no back-to-back events observed anywhere
        check("R10", pairs, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule